// File: doc/BRIEF.md
# Watchdog Timer with Interrupt-Before-Reset

The block counts cycles of its own clock and compares the count against a 32-bit time-out limit that software loads as two 16-bit halves. If software fails to pulse the refresh input before the count reaches the limit, a time-out fault is raised. An external fault input can also raise a fault, and it does so even while the counter is switched off.

What happens on a fault depends on a control bit. If the interrupt-first mode is off, the reset request rises on the next clock. If it is on, a sticky interrupt flag is set and drives the interrupt output at once. The reset request then follows a fixed `WCT` cycles later, which gives software a grace window to save state. Once raised, the reset request stays high until the block's own synchronous reset is applied.

Changes to the run/stop bit are filtered. A new value must stay in the register across two consecutive clock edges before the counter sees it, so a one-cycle glitch on the bit is ignored.

Top module: `wdt_core`

## Requirements
- R1: After reset, register 0 reads 0x0001, register 1 reads 0x0001, register 2 reads 0x004C and register 3 reads 0x4B4C. Both outputs are low. Register 0 bit 0 is the run bit and bit 1 is the interrupt-first bit. Register 1 bit 15 is the interrupt flag and bit 0 always reads 1. Register 2 holds the upper half of the time-out and register 3 the lower half.
- R2: A written run-bit value reaches the counter only if it is still in the register at the second clock edge after the write edge. A value that is overwritten one cycle later never reaches the counter.
- R3: While the counter is stopped it is held at zero and no time-out occurs. After a restart it counts up from zero. The run bit is written at edge k and takes effect at edge k+2, so with a limit T the fault is seen at edge k+T+3.
- R4: A refresh pulse sampled at edge r clears the count while running. With limit T the time-out fault is registered at edge r+T+1, and periodic refreshes inside the limit prevent any fault.
- R5: An external fault raises the fault path even while the counter is stopped.
- R6: With the interrupt-first bit set, a fault sampled at edge k sets the flag and the interrupt output after edge k, and the reset output rises after edge k+WCT.
- R7: With the interrupt-first bit clear, a fault sampled at edge k raises the reset output after edge k. The interrupt output and the flag stay low.
- R8: Writing 1 to register 1 bit 15 clears the flag and the interrupt output, while writing 0 leaves them unchanged. An already started grace window still ends in reset.
- R9: The reset output stays high until the synchronous reset is applied, and that reset clears the flag and the reset output.
- R10: The time-out limit is the full 32-bit value formed from the two halves. A nonzero upper half defers the time-out, and lowering the limit below the current count faults on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst | input | 1 | Synchronous active-high system reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for both write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| refresh | input | 1 | Refresh pulse that restarts the count |
| ext_fault | input | 1 | External fault request |
| wd_irq | output | 1 | Interrupt output, equal to the flag |
| wd_reset_req | output | 1 | Sticky reset request |

## Verification
The bench checks the exact cycles of the interrupt and reset edges: one cycle after the limit for the interrupt, and `WCT` cycles later for the reset. A design off by one register, or one whose grace counter stops one cycle early, misses these edges. It glitches the run bit for one cycle and expects the count to carry on undisturbed; a design without the hold filter would restart the count and fault late. Further checks fire the external fault while the counter is stopped, clear the flag inside the grace window and still expect the reset, and put a nonzero upper half in the limit. These catch a design that gates every fault with the run bit, lets a flag clear cancel the reset, or compares only 16 bits.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned HALF_W = 16;
    localparam int unsigned TOV_W  = 2 * HALF_W;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_STAT   = 2'd1,
        REG_TOV_HI = 2'd2,
        REG_TOV_LO = 2'd3
    } reg_sel_e;

    localparam int unsigned CTRL_RUN_BIT   = 0;
    localparam int unsigned CTRL_IRQF_BIT  = 1;
    localparam int unsigned STAT_FLAG_BIT  = 15;
    localparam int unsigned STAT_FIXED_BIT = 0;

    typedef struct packed {
        logic irq_first;
        logic run;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{irq_first: 1'b0, run: 1'b1};

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        logic [HALF_W-1:0] data;
    } reg_wr_t;

    typedef enum logic [1:0] {
        SEQ_ARMED,
        SEQ_GRACE,
        SEQ_RESET
    } seq_e;

    function automatic logic [HALF_W-1:0] pack_ctrl(ctrl_t c);
        logic [HALF_W-1:0] v;
        v = '0;
        v[CTRL_RUN_BIT]  = c.run;
        v[CTRL_IRQF_BIT] = c.irq_first;
        return v;
    endfunction

    function automatic logic [HALF_W-1:0] pack_stat(logic flag);
        logic [HALF_W-1:0] v;
        v = '0;
        v[STAT_FLAG_BIT]  = flag;
        v[STAT_FIXED_BIT] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter logic [TOV_W-1:0] TOV_RESET = 32'h004C_4B4C
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr,
    input  reg_sel_e          rsel,
    input  logic              flag,
    output ctrl_t             ctrl,
    output logic [TOV_W-1:0]  tov,
    output logic              flag_clr,
    output logic [HALF_W-1:0] rdata
);

    logic [HALF_W-1:0] tov_hi_q, tov_lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= CTRL_RESET;
            tov_hi_q <= TOV_RESET[TOV_W-1:HALF_W];
            tov_lo_q <= TOV_RESET[HALF_W-1:0];
        end else if (wr.we) begin
            case (wr.sel)
                REG_CTRL: begin
                    ctrl.run       <= wr.data[CTRL_RUN_BIT];
                    ctrl.irq_first <= wr.data[CTRL_IRQF_BIT];
                end
                REG_TOV_HI: tov_hi_q <= wr.data;
                REG_TOV_LO: tov_lo_q <= wr.data;
                default: ;
            endcase
        end
    end

    assign tov      = {tov_hi_q, tov_lo_q};
    assign flag_clr = wr.we && (wr.sel == REG_STAT) && wr.data[STAT_FLAG_BIT];

    always_comb begin
        case (rsel)
            REG_CTRL:   rdata = pack_ctrl(ctrl);
            REG_STAT:   rdata = pack_stat(flag);
            REG_TOV_HI: rdata = tov_hi_q;
            default:    rdata = tov_lo_q;
        endcase
    end

endmodule

// File: rtl/wdt_en_qual.sv
module wdt_en_qual #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic en_eff
);

    logic req_d1;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d1 <= RESET_VAL;
            en_eff <= RESET_VAL;
        end else begin
            req_d1 <= req;
            if (req == req_d1) begin
                en_eff <= req;
            end
        end
    end

    // a new applied value must have sat in the register for two edges
    assert_en_held_R2: assert property (@(posedge clk) disable iff (rst)
        (en_eff != $past(en_eff)) |-> ($past(req) == en_eff && $past(req, 2) == en_eff));

endmodule

// File: rtl/wdt_count.sv
module wdt_count
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             refresh,
    input  logic [TOV_W-1:0] tov,
    output logic             tmo
);

    logic [TOV_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst || !en || refresh) begin
            count <= '0;
        end else if (count < tov) begin
            count <= count + 1'b1;
        end
    end

    assign tmo = en && (count >= tov);

    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (rst)
        !en |=> (count == '0 && !tmo));

    assert_refresh_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (en && refresh) |=> (count == '0));

endmodule

// File: rtl/wdt_seq.sv
module wdt_seq
    import wdt_pkg::*;
#(
    parameter int unsigned WCT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic fault,
    input  logic irq_first,
    input  logic flag_clr,
    output logic flag,
    output logic reset_req
);

    localparam int unsigned GW = $clog2(WCT + 1);
    localparam logic [GW-1:0] GRACE_LAST = GW'(WCT - 1);

    seq_e          state;
    logic [GW-1:0] grace_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_ARMED;
            grace_cnt <= '0;
        end else begin
            case (state)
                SEQ_ARMED: begin
                    grace_cnt <= '0;
                    if (fault) begin
                        state <= irq_first ? SEQ_GRACE : SEQ_RESET;
                    end
                end
                SEQ_GRACE: begin
                    if (grace_cnt == GRACE_LAST) begin
                        state <= SEQ_RESET;
                    end else begin
                        grace_cnt <= grace_cnt + 1'b1;
                    end
                end
                default: state <= SEQ_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (state == SEQ_ARMED && fault && irq_first) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    assign reset_req = (state == SEQ_RESET);

    assert_flag_needs_mode_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(irq_first));

    assert_direct_reset_R7: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_ARMED && fault && !irq_first) |=> (reset_req && !flag));

    assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
        (flag && flag_clr) |=> !flag);

    assert_reset_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> reset_req);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int unsigned      WCT       = 256,
    parameter logic [TOV_W-1:0] TOV_RESET = 32'h004C_4B4C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [HALF_W-1:0] reg_wdata,
    output logic [HALF_W-1:0] reg_rdata,
    input  logic              refresh,
    input  logic              ext_fault,
    output logic              wd_irq,
    output logic              wd_reset_req
);

    reg_wr_t          wr;
    ctrl_t            ctrl;
    logic [TOV_W-1:0] tov;
    logic             flag, flag_clr, run_eff, tmo;

    assign wr = '{we: reg_we, sel: reg_sel_e'(reg_addr), data: reg_wdata};

    wdt_regs #(.TOV_RESET(TOV_RESET)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .rsel     (reg_sel_e'(reg_addr)),
        .flag     (flag),
        .ctrl     (ctrl),
        .tov      (tov),
        .flag_clr (flag_clr),
        .rdata    (reg_rdata)
    );

    wdt_en_qual #(.RESET_VAL(CTRL_RESET.run)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .req    (ctrl.run),
        .en_eff (run_eff)
    );

    wdt_count u_count (
        .clk     (clk),
        .rst     (rst),
        .en      (run_eff),
        .refresh (refresh),
        .tov     (tov),
        .tmo     (tmo)
    );

    wdt_seq #(.WCT(WCT)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .fault     (tmo || ext_fault),
        .irq_first (ctrl.irq_first),
        .flag_clr  (flag_clr),
        .flag      (flag),
        .reset_req (wd_reset_req)
    );

    assign wd_irq = flag;

    assert_ext_fault_R5: assert property (@(posedge clk) disable iff (rst)
        (ext_fault && !wd_irq && !wd_reset_req) |=> (wd_irq || wd_reset_req));

endmodule

// File: tb/sim_wdt_core.sv
module sim_wdt_core;

    localparam int WCT = 16;

    typedef struct {
        int    cyc;
        bit    irq;
        bit    rst;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        refresh = 1'b0;
    logic        ext_fault = 1'b0;
    logic        wd_irq, wd_reset_req;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_core #(.WCT(WCT)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .refresh(refresh),
        .ext_fault(ext_fault), .wd_irq(wd_irq), .wd_reset_req(wd_reset_req)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: pops expected output pairs at their cycle and compares
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.cyc == cyc && wd_irq == e.irq && wd_reset_req == e.rst, e.req,
                {30'd0, wd_irq, wd_reset_req}, {30'd0, e.irq, e.rst});
        end
    end

    task automatic expect_abs(int at, bit irq, bit r, string req);
        exp_t e;
        e.cyc = at; e.irq = irq; e.rst = r; e.req = req;
        sb.push_back(e);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [15:0] exp, string req);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, {16'd0, reg_rdata}, {16'd0, exp});
    endtask

    task automatic pulse_refresh();
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
    endtask

    task automatic sys_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic setup(logic [15:0] ctl, logic [31:0] tov);
        wr(2'd0, ctl);
        wr(2'd2, tov[31:16]);
        wr(2'd3, tov[15:0]);
    endtask

    task automatic out_chk(bit irq, bit r, string req);
        chk(wd_irq == irq && wd_reset_req == r, req,
            {30'd0, wd_irq, wd_reset_req}, {30'd0, irq, r});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        int r, k, t0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, 16'h0001, "R1 ctrl");
        rd(2'd1, 16'h0001, "R1 stat");
        rd(2'd2, 16'h004C, "R1 tov hi");
        rd(2'd3, 16'h4B4C, "R1 tov lo");
        out_chk(0, 0, "R1 outputs");

        // R7 direct reset, R9 sticky, R10 readback
        setup(16'h0001, 32'd20);
        rd(2'd3, 16'd20, "R10 tov lo readback");
        rd(2'd2, 16'd0, "R10 tov hi readback");
        pulse_refresh(); r = cyc;
        expect_abs(r + 20, 0, 0, "R4 before limit");
        expect_abs(r + 21, 0, 1, "R7 direct reset");
        expect_abs(r + 60, 0, 1, "R9 reset sticky");
        drain();
        rd(2'd1, 16'h0001, "R7 flag stays clear");
        sys_reset();
        out_chk(0, 0, "R9 reset clears outputs");

        // R6 interrupt then reset
        setup(16'h0003, 32'd20);
        pulse_refresh(); r = cyc;
        expect_abs(r + 20, 0, 0, "R6 before limit");
        expect_abs(r + 21, 1, 0, "R6 irq first");
        expect_abs(r + 20 + WCT, 1, 0, "R6 grace not over");
        expect_abs(r + 21 + WCT, 1, 1, "R6 reset after WCT");
        drain();
        rd(2'd1, 16'h8001, "R6 flag visible");
        sys_reset();
        rd(2'd1, 16'h0001, "R9 reset clears flag");
        out_chk(0, 0, "R9 outputs after reset");

        // R8 write-1-to-clear
        setup(16'h0003, 32'd20);
        pulse_refresh(); r = cyc;
        t0 = r + 21;
        expect_abs(t0, 1, 0, "R8 irq raised");
        drain();
        wr(2'd1, 16'h0000);
        rd(2'd1, 16'h8001, "R8 write 0 keeps flag");
        wr(2'd1, 16'h8000);
        rd(2'd1, 16'h0001, "R8 write 1 clears flag");
        out_chk(0, 0, "R8 irq dropped");
        expect_abs(t0 + WCT - 1, 0, 0, "R8 grace continues");
        expect_abs(t0 + WCT, 0, 1, "R8 reset still follows");
        drain();
        sys_reset();

        // R4 periodic refresh
        setup(16'h0003, 32'd20);
        for (int i = 0; i < 8; i++) begin
            pulse_refresh();
            repeat (15) @(negedge clk);
            out_chk(0, 0, "R4 refreshed no fault");
        end
        pulse_refresh(); r = cyc;
        expect_abs(r + 20, 0, 0, "R4 last refresh holds");
        expect_abs(r + 21, 1, 0, "R4 fault after limit");
        drain();
        sys_reset();

        // R3 stopped counter, restart from zero
        setup(16'h0002, 32'd20);
        repeat (100) @(negedge clk);
        out_chk(0, 0, "R3 stopped no fault");
        wr(2'd0, 16'h0003); k = cyc;
        expect_abs(k + 22, 0, 0, "R3 restart before limit");
        expect_abs(k + 23, 1, 0, "R3 restart fault");
        drain();
        sys_reset();

        // R2 one-cycle glitch on run bit is ignored
        setup(16'h0003, 32'd40);
        pulse_refresh(); r = cyc;
        wr(2'd0, 16'h0002);
        wr(2'd0, 16'h0003);
        expect_abs(r + 40, 0, 0, "R2 glitch ignored early");
        expect_abs(r + 41, 1, 0, "R2 glitch ignored timing");
        drain();
        sys_reset();

        // R5 external fault while stopped
        setup(16'h0002, 32'd20);
        repeat (50) @(negedge clk);
        out_chk(0, 0, "R5 idle while stopped");
        expect_abs(cyc + 1, 1, 0, "R5 ext fault irq");
        expect_abs(cyc + WCT + 1, 1, 1, "R5 ext fault reset");
        ext_fault = 1'b1;
        @(negedge clk);
        ext_fault = 1'b0;
        drain();
        sys_reset();

        // R10 full 32-bit limit
        setup(16'h0003, 32'h0001_0005);
        pulse_refresh();
        repeat (100) @(negedge clk);
        out_chk(0, 0, "R10 upper half defers");
        wr(2'd2, 16'h0000);
        expect_abs(cyc + 1, 1, 0, "R10 lowered limit faults");
        drain();
        sys_reset();

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule